// File: doc/BRIEF.md
# Cascaded 32-bit Input-Capture Timer

Two 16-bit counting channels are chained so that together they form one 32-bit count. The lower channel advances on each cycle in which the count-enable tick is high. The upper channel advances only when the lower one rolls over from its all-ones value to zero. Each channel has its own capture register. Together the two capture registers hold a consistent 32-bit snapshot of the running count.

A channel captures on an edge of its own input pin. Each channel has a 2-bit edge selector: no edge, rising, falling or both. A cross-enable bit per channel ORs the partner channel's pin into the capture condition, qualified by the same edge selector. The upper channel can instead take its capture trigger from an external strobe that reports a compare or capture event of a separate channel. In that mode neither pin affects the upper capture, and the cross-enable is ignored. Software sets up the block and reads results through a small register port. Pins pass through a synchronizer before edge detection.

Top module: `cascade_capture_timer`

## Requirements
- R1: The low counter (address 0) increments by one at each clock edge where `count_tick` is high and no write targets it, and holds otherwise.
- R2: The high counter (address 1) increments by one exactly when a tick moves the low counter from 0xFFFF to 0x0000; the pair therefore forms one 32-bit count.
- R3: A write to a counter address loads that counter at the clock edge, taking priority over counting in the same cycle; a write to the low counter also cancels the carry into the high counter for that cycle.
- R4: Each channel's edge selector uses the code 00 = no capture, 01 = rising, 10 = falling, 11 = both edges. The selector for the low channel is control bits [1:0] and the one for the high channel is bits [3:2].
- R5: A pin transition applied before clock edge k makes a qualifying channel capture at edge k+2. The capture registers (low at address 2, high at address 3) store the counter values present before that edge, so a capture coincident with a wrap holds the pre-wrap 32-bit value.
- R6: Control bit 4 ORs edges of the high pin into the low channel's capture condition, qualified by the low channel's selector.
- R7: Control bit 5 ORs edges of the low pin into the high channel's capture condition, qualified by the high channel's selector.
- R8: With control bit 6 set, the high channel captures at each clock edge where `ch0_event` is high, and no pin edge on either pin causes a high capture, even with bit 5 set.
- R9: With bits 4 and 5 set and both selectors at 11, an edge on either pin loads both capture registers at the same edge.
- R10: Reset clears all counters, capture registers and control bits. Address 4 reads the control field in bits [6:0] with zeros above. Unused addresses read zero. Writes to the capture addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| pin_lo | input | 1 | Low channel capture pin (asynchronous) |
| pin_hi | input | 1 | High channel capture pin (asynchronous) |
| ch0_event | input | 1 | Synchronous strobe of an external channel's compare/capture event |
| count_tick | input | 1 | Count enable, one increment per high cycle |

## Verification
Counter writes and ticks take effect at the first clock edge after they are driven. A `ch0_event` capture also lands at that first edge. A pin edge captures at the third edge after it is driven, because it passes two synchronizer flops and an edge-detect flop. The bench keeps a cycle-stepped reference model that advances one edge per stimulus cycle and applies those same delays. Every read is sampled at the falling edge that follows the edge the result is due on, so the model and the design are compared on the same cycle.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      hi_src_ext;
    logic      xen_hi;
    logic      xen_lo;
    edge_sel_e hi_edge;
    edge_sel_e lo_edge;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] ADR_CNT_LO = 3'd0;
  localparam logic [2:0] ADR_CNT_HI = 3'd1;
  localparam logic [2:0] ADR_CAP_LO = 3'd2;
  localparam logic [2:0] ADR_CAP_HI = 3'd3;
  localparam logic [2:0] ADR_CTRL   = 3'd4;

  function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction

endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/cct_trigger.sv
module cct_trigger
  import cct_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  lo_rise,
  input  logic  lo_fall,
  input  logic  hi_rise,
  input  logic  hi_fall,
  input  logic  ch0_event,
  output logic  cap_lo_stb,
  output logic  cap_hi_stb
);

  logic lo_own, lo_cross, hi_own, hi_cross;

  always_comb begin
    lo_own   = edge_hit(ctrl.lo_edge, lo_rise, lo_fall);
    lo_cross = ctrl.xen_lo & edge_hit(ctrl.lo_edge, hi_rise, hi_fall);
    hi_own   = edge_hit(ctrl.hi_edge, hi_rise, hi_fall);
    hi_cross = ctrl.xen_hi & edge_hit(ctrl.hi_edge, lo_rise, lo_fall);

    cap_lo_stb = lo_own | lo_cross;
    if (ctrl.hi_src_ext) cap_hi_stb = ch0_event;
    else                 cap_hi_stb = hi_own | hi_cross;
  end

endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] lo_d, hi_d;
  logic         lo_en, hi_en, carry;

  always_comb begin
    carry = tick & (cnt_lo == ALL_ONES) & ~wr_lo;
    lo_en = wr_lo | tick;
    hi_en = wr_hi | carry;
    lo_d  = wr_lo ? wr_data : cnt_lo + 1'b1;
    hi_d  = wr_hi ? wr_data : cnt_hi + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      if (lo_en) cnt_lo <= lo_d;
      if (hi_en) cnt_hi <= hi_d;
    end
  end

endmodule

// File: rtl/cascade_capture_timer.sv
module cascade_capture_timer
  import cct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              pin_lo,
  input  logic              pin_hi,
  input  logic              ch0_event,
  input  logic              count_tick
);

  localparam int NPIN = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // address decode
  logic wr_cnt_lo, wr_cnt_hi, wr_ctrl;
  always_comb begin
    wr_cnt_lo = wr_en & (wr_addr == ADDR_W'(ADR_CNT_LO));
    wr_cnt_hi = wr_en & (wr_addr == ADDR_W'(ADR_CNT_HI));
    wr_ctrl   = wr_en & (wr_addr == ADDR_W'(ADR_CTRL));
  end

  // control register
  ctrl_t ctrl_q, ctrl_d;
  always_comb ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  // pin synchronizers, index 0 = low channel, 1 = high channel
  logic [NPIN-1:0] pin_vec, rise_vec, fall_vec;
  assign pin_vec = {pin_hi, pin_lo};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    cct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .pin  (pin_vec[g]),
      .rise (rise_vec[g]),
      .fall (fall_vec[g])
    );
  end

  logic cap_lo_stb, cap_hi_stb;
  cct_trigger u_trig (
    .ctrl      (ctrl_q),
    .lo_rise   (rise_vec[0]),
    .lo_fall   (fall_vec[0]),
    .hi_rise   (rise_vec[1]),
    .hi_fall   (fall_vec[1]),
    .ch0_event (ch0_event),
    .cap_lo_stb(cap_lo_stb),
    .cap_hi_stb(cap_hi_stb)
  );

  logic [CNT_W-1:0] cnt_lo, cnt_hi;
  cct_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (count_tick),
    .wr_lo  (wr_cnt_lo),
    .wr_hi  (wr_cnt_hi),
    .wr_data(wr_data),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi)
  );

  // capture registers take the pre-increment count
  logic [CNT_W-1:0] cap_lo_q, cap_hi_q, cap_lo_d, cap_hi_d;
  always_comb begin
    cap_lo_d = cnt_lo;
    cap_hi_d = cnt_hi;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cap_lo_q <= '0;
      cap_hi_q <= '0;
    end else begin
      if (cap_lo_stb) cap_lo_q <= cap_lo_d;
      if (cap_hi_stb) cap_hi_q <= cap_hi_d;
    end
  end

  // read port
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADDR_W'(ADR_CNT_LO): rd_data = cnt_lo;
      ADDR_W'(ADR_CNT_HI): rd_data = cnt_hi;
      ADDR_W'(ADR_CAP_LO): rd_data = cap_lo_q;
      ADDR_W'(ADR_CAP_HI): rd_data = cap_hi_q;
      ADDR_W'(ADR_CTRL):   rd_data = CNT_W'(ctrl_q);
      default:             rd_data = '0;
    endcase
  end

endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic              count_tick,
  input logic              ch0_event,
  input logic              hi_src_ext,
  input logic              cap_lo_stb,
  input logic              cap_hi_stb,
  input logic [CNT_W-1:0]  cnt_lo,
  input logic [CNT_W-1:0]  cnt_hi,
  input logic [CNT_W-1:0]  cap_lo_q,
  input logic [CNT_W-1:0]  cap_hi_q
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic wr_lo, wr_hi;
  assign wr_lo = wr_en & (wr_addr == ADDR_W'(0));
  assign wr_hi = wr_en & (wr_addr == ADDR_W'(1));

  assert_lo_hold_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!count_tick && !wr_lo) |=> $stable(cnt_lo));

  assert_carry_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (count_tick && cnt_lo == ALL_ONES && !wr_lo && !wr_hi)
      |=> cnt_hi == CNT_W'($past(cnt_hi) + 1'b1));

  assert_write_lo_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_lo |=> cnt_lo == $past(wr_data));

  assert_capture_lo_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_lo_stb |=> cap_lo_q == $past(cnt_lo));

  assert_capture_hi_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_hi_stb |=> cap_hi_q == $past(cnt_hi));

  assert_ext_src_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hi_src_ext && !ch0_event) |=> $stable(cap_hi_q));

endmodule

bind cascade_capture_timer cct_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .count_tick(count_tick),
  .ch0_event (ch0_event),
  .hi_src_ext(ctrl_q.hi_src_ext),
  .cap_lo_stb(cap_lo_stb),
  .cap_hi_stb(cap_hi_stb),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .cap_lo_q  (cap_lo_q),
  .cap_hi_q  (cap_hi_q)
);

// File: tb/cascade_capture_timer_tb.sv
`timescale 1ns/1ps
module cascade_capture_timer_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        pin_lo, pin_hi, ch0_event, count_tick;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  cascade_capture_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_lo(pin_lo), .pin_hi(pin_hi), .ch0_event(ch0_event),
    .count_tick(count_tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model state
  logic [15:0] m_lo, m_hi, m_clo, m_chi;
  logic [6:0]  m_ctrl;
  logic        s1l, s2l, pl, s1h, s2h, ph;

  function automatic logic hit(logic [1:0] sel, logic r, logic f);
    return (sel[0] & r) | (sel[1] & f);
  endfunction

  task automatic model_reset();
    m_lo = 0; m_hi = 0; m_clo = 0; m_chi = 0; m_ctrl = 0;
    s1l = 0; s2l = 0; pl = 0; s1h = 0; s2h = 0; ph = 0;
  endtask

  // one clock: inputs applied at current (negedge) time, returns at next negedge
  task automatic cyc(input logic wr, input logic [2:0] a, input logic [15:0] d,
                     input logic tk, input logic c0);
    logic lr, lf, hr, hf, tlo, thi, carry;
    logic [15:0] n_lo, n_hi;
    wr_en = wr; wr_addr = a; wr_data = d; count_tick = tk; ch0_event = c0;
    lr = s2l & ~pl; lf = ~s2l & pl;
    hr = s2h & ~ph; hf = ~s2h & ph;
    tlo = hit(m_ctrl[1:0], lr, lf) | (m_ctrl[4] & hit(m_ctrl[1:0], hr, hf));
    thi = m_ctrl[6] ? c0 : (hit(m_ctrl[3:2], hr, hf) | (m_ctrl[5] & hit(m_ctrl[3:2], lr, lf)));
    carry = tk && m_lo == 16'hFFFF && !(wr && a == 3'd0);
    n_lo = (wr && a == 3'd0) ? d : (tk ? m_lo + 16'd1 : m_lo);
    n_hi = (wr && a == 3'd1) ? d : (carry ? m_hi + 16'd1 : m_hi);
    @(posedge clk);
    if (tlo) m_clo = m_lo;
    if (thi) m_chi = m_hi;
    m_lo = n_lo; m_hi = n_hi;
    if (wr && a == 3'd4) m_ctrl = d[6:0];
    pl = s2l; s2l = s1l; s1l = pin_lo;
    ph = s2h; s2h = s1h; s1h = pin_hi;
    @(negedge clk);
    wr_en = 0; count_tick = 0; ch0_event = 0;
  endtask

  task automatic idle(input int n, input logic tk);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 16'd0, tk, 1'b0);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_model(input string req);
    chk(req, 3'd0, m_lo);
    chk(req, 3'd1, m_hi);
    chk(req, 3'd2, m_clo);
    chk(req, 3'd3, m_chi);
    chk(req, 3'd4, {9'd0, m_ctrl});
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : main
    logic [15:0] held;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    pin_lo = 0; pin_hi = 0; ch0_event = 0; count_tick = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R10 reset state and map
    chk("R10 reset cnt_lo", 3'd0, 16'h0);
    chk("R10 reset cnt_hi", 3'd1, 16'h0);
    chk("R10 reset cap_lo", 3'd2, 16'h0);
    chk("R10 reset cap_hi", 3'd3, 16'h0);
    chk("R10 reset ctrl",   3'd4, 16'h0);
    chk("R10 unused addr",  3'd7, 16'h0);

    // R1 count and hold
    wreg(3'd0, 16'h0005);
    idle(3, 1'b1);
    idle(2, 1'b0);
    chk("R1 low count", 3'd0, 16'h0008);

    // R2 wrap carry
    wreg(3'd0, 16'hFFFE);
    wreg(3'd1, 16'h0007);
    idle(3, 1'b1);
    chk("R2 low after wrap", 3'd0, 16'h0001);
    chk("R2 high carry", 3'd1, 16'h0008);

    // R3 write beats count, cancels carry
    wreg(3'd0, 16'hFFFF);
    cyc(1'b1, 3'd0, 16'h1234, 1'b1, 1'b0);
    chk("R3 write priority low", 3'd0, 16'h1234);
    chk("R3 carry cancelled", 3'd1, 16'h0008);

    // R10 capture addresses are not writable
    wreg(3'd2, 16'hBEEF);
    wreg(3'd3, 16'hBEEF);
    chk("R10 cap_lo write ignored", 3'd2, 16'h0);
    chk("R10 cap_hi write ignored", 3'd3, 16'h0);

    // R4 R5 rising capture latency
    wreg(3'd4, 16'h0001);
    wreg(3'd0, 16'h0100);
    pin_lo = 1;
    idle(3, 1'b1);
    idle(3, 1'b0);
    chk("R5 cap_lo pre-increment value", 3'd2, 16'h0102);
    chk("R4 high channel idle", 3'd3, 16'h0);
    pin_lo = 0;
    idle(5, 1'b1);
    chk("R4 falling edge ignored with rise select", 3'd2, 16'h0102);

    // R8 external source suppresses pins and cross-enable
    wreg(3'd1, 16'h0033);
    wreg(3'd4, 16'h007C);   // hi_src=1, xen both, hi_edge=both, lo_edge=none
    held = m_chi;
    pin_lo = 1; idle(4, 1'b1);
    pin_hi = 1; idle(4, 1'b1);
    pin_lo = 0; pin_hi = 0; idle(4, 1'b1);
    chk("R8 pins ignored in ext mode", 3'd3, held);
    cyc(1'b0, 3'd0, 16'd0, 1'b0, 1'b1);
    chk("R8 ext strobe captures high", 3'd3, 16'h0033);

    // R9 both cross-enables, capture on the wrapping edge
    wreg(3'd4, 16'h003F);
    wreg(3'd0, 16'hFFFD);
    wreg(3'd1, 16'h0041);
    pin_hi = 1;
    idle(3, 1'b1);
    idle(2, 1'b0);
    chk("R9 cap_lo from partner pin", 3'd2, 16'hFFFF);
    chk("R9 cap_hi same edge", 3'd3, 16'h0041);
    chk("R9 R2 count after wrap", 3'd1, 16'h0042);
    pin_hi = 0;
    idle(4, 1'b0);

    // random phases against the model (R1 R2 R4 R5 R6 R7 R8)
    void'($urandom(32'd12345));
    for (int ph_i = 0; ph_i < 40; ph_i++) begin
      wreg(3'd4, 16'($urandom_range(0, 127)));
      wreg(3'd0, 16'hFFC0 | 16'($urandom_range(0, 63)));
      for (int c = 0; c < 300; c++) begin
        if ($urandom_range(0, 9) == 0) pin_lo = ~pin_lo;
        if ($urandom_range(0, 11) == 0) pin_hi = ~pin_hi;
        cyc(1'b0, 3'd0, 16'd0, ($urandom_range(0, 3) != 0), ($urandom_range(0, 15) == 0));
      end
      chk_model("R1 R2 R4 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule